// File: doc/BRIEF.md
# Serial Flash Sector Lock Command Front End

This block is the serial command front end of a flash device, cut down to the sector lock function. A host talks to it over a four-wire serial link in clock mode 0, with clock idle low and data sampled on the rising clock edge while chip select is low. The block understands two commands. One sets a write-enable latch. The other writes one sector's volatile lock register. Each sector has a 2-bit lock state: a write-protect bit and a lock-down bit. A parallel port reads back the lock state of any sector at any time.

The serial pins are oversampled by the block's system clock. They must be stable around system clock edges, and each serial clock level must last at least one system clock. A lock write is a 40-bit frame made of an opcode byte, a 24-bit address sent MSB first, and one data byte. It takes effect on the system clock edge that follows the rise of chip select. The write only happens if the frame length is exactly 40 bits, the write-enable latch is set and the busy input is low. There is no data stream with back-pressure here. The serial link is fire-and-forget, and every pin is plain control or status.

Top module: `lockreg_spi_top`

## Requirements
- R1: After reset, the lock state of every sector reads 0x00 and the write-enable latch output is 0. A reset in the middle of operation returns the block to this state.
- R2: A frame of exactly 8 bits carrying opcode 0x06 sets the write-enable latch. An 0x06 frame of any other length leaves the latch unchanged.
- R3: A frame of exactly 40 bits carrying opcode 0xE5, with the latch set and busy low, updates the addressed sector: read bit 0 takes data bit 0 (write protect) and read bit 1 takes data bit 1 (lock-down). Read bits 7 to 2 are always 0, whatever the data byte holds.
- R4: The sector number is address bits [20:16], which gives 32 sectors. The low 16 address bits do not affect which register is written.
- R5: A 0xE5 frame sent while the write-enable latch is clear changes no lock state.
- R6: A 0xE5 frame whose chip select rises after any bit count other than 40 changes nothing, and the latch keeps its value.
- R7: A 0xE5 frame that ends while busy is high is rejected: no lock state changes and the latch keeps its value.
- R8: A 0xE5 frame that meets all the conditions of R3 clears the write-enable latch.
- R9: Once a sector's lock-down bit is 1, later 0xE5 frames to that sector leave its lock state unchanged until reset. Such a frame still clears the latch.
- R10: Bit and byte counting restart whenever chip select is high, so a frame that is cut off does not disturb the next one.
- R11: A frame with any opcode other than 0x06 or 0xE5 changes neither the lock state nor the latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sclk | input | 1 | Serial clock, idle low, data sampled on its rising edge |
| spi_mosi | input | 1 | Serial data in, MSB first |
| busy_in | input | 1 | High while an erase, program or write cycle is running |
| rd_sector | input | 5 | Sector number for the read port |
| rd_lock | output | 8 | Lock state of rd_sector: bit 1 lock-down, bit 0 write protect |
| wel_o | output | 1 | Write-enable latch |

## Verification
The hardest cases to reach are frames that are correct in every respect except one condition. Examples are a frame one bit short or one bit long while the latch is set, and a well-formed frame that ends while busy is high. Each needs the latch to already be set, and it must stay set so that the next case still starts with it armed. The vector table therefore orders these rejections one after another so the latch carries from row to row. The frame sender takes an arbitrary bit count, so chip select can rise at any position. A lock-down row followed later by a write to the same sector checks that R9 holds across unrelated traffic.

// File: rtl/lockreg_pkg.sv
package lockreg_pkg;
  localparam int unsigned NUM_SECTORS = 32;
  localparam int unsigned SEC_W       = $clog2(NUM_SECTORS);
  localparam int unsigned CNT_W       = 6;
  localparam int unsigned FRAME_BITS  = 40;
  localparam int unsigned CMD_BITS    = 8;
  localparam logic [7:0]  OP_WREN     = 8'h06;
  localparam logic [7:0]  OP_LOCKWR   = 8'hE5;

  // byte positions inside a lock-write frame
  typedef enum logic [2:0] {
    POS_OPCODE = 3'd0,
    POS_ADDR_H = 3'd1,
    POS_ADDR_M = 3'd2,
    POS_ADDR_L = 3'd3,
    POS_DATA   = 3'd4
  } byte_pos_e;
endpackage

// File: rtl/spi_bit_rx.sv
module spi_bit_rx
  import lockreg_pkg::*;
#(
  parameter int unsigned CW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          sclk,
  input  logic          mosi,
  output logic          byte_stb,
  output logic [7:0]    byte_val,
  output logic [2:0]    byte_idx,
  output logic          frame_end,
  output logic [CW-1:0] bit_cnt
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  logic       sclk_q, cs_q;
  logic [6:0] shift_q;
  logic       rise;

  assign rise      = sclk & ~sclk_q & ~cs_n;
  assign frame_end = cs_n & ~cs_q;
  assign byte_stb  = rise && (bit_cnt[2:0] == 3'd7);
  assign byte_val  = {shift_q, mosi};
  assign byte_idx  = bit_cnt[5:3];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      cs_q    <= 1'b1;
      shift_q <= '0;
      bit_cnt <= '0;
    end else begin
      sclk_q <= sclk;
      cs_q   <= cs_n;
      if (cs_n) begin
        bit_cnt <= '0;
        shift_q <= '0;
      end else if (rise) begin
        shift_q <= {shift_q[5:0], mosi};
        if (bit_cnt != CNT_MAX) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end

  // R10
  cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (bit_cnt == '0));
endmodule

// File: rtl/lockreg_decode.sv
module lockreg_decode
  import lockreg_pkg::*;
#(
  parameter int unsigned CW = CNT_W,
  parameter int unsigned SW = SEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          byte_stb,
  input  logic [7:0]    byte_val,
  input  logic [2:0]    byte_idx,
  input  logic          frame_end,
  input  logic [CW-1:0] bit_cnt,
  input  logic          busy_in,
  output logic          wr_en,
  output logic [SW-1:0] wr_sector,
  output logic [1:0]    wr_bits,
  output logic          wel_q
);
  logic [7:0]    op_q;
  logic [SW-1:0] sec_q;
  logic [1:0]    dat_q;
  logic          wren_ok;

  assign wren_ok   = frame_end && (op_q == OP_WREN) && (bit_cnt == CW'(CMD_BITS));
  assign wr_en     = frame_end && (op_q == OP_LOCKWR) && (bit_cnt == CW'(FRAME_BITS))
                     && wel_q && !busy_in;
  assign wr_sector = sec_q;
  assign wr_bits   = dat_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      op_q  <= '0;
      sec_q <= '0;
      dat_q <= '0;
      wel_q <= 1'b0;
    end else begin
      if (byte_stb) begin
        unique case (byte_pos_e'(byte_idx))
          POS_OPCODE: op_q  <= byte_val;
          POS_ADDR_H: sec_q <= byte_val[SW-1:0];
          POS_DATA:   dat_q <= byte_val[1:0];
          default: ;
        endcase
      end
      if (wren_ok)    wel_q <= 1'b1;
      else if (wr_en) wel_q <= 1'b0;
    end
  end

  // R2
  wel_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && op_q == OP_WREN && bit_cnt == CW'(CMD_BITS)) |=> wel_q);
  // R7
  busy_keep_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end && busy_in && wel_q) |=> wel_q);
endmodule

// File: rtl/lockreg_bank.sv
module lockreg_bank
  import lockreg_pkg::*;
#(
  parameter int unsigned NS = NUM_SECTORS,
  parameter int unsigned SW = SEC_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_sector,
  input  logic [1:0]    wr_bits,
  input  logic [SW-1:0] rd_sector,
  output logic [7:0]    rd_lock
);
  logic [1:0] lk_q [NS];

  for (genvar g = 0; g < NS; g++) begin : g_sec
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lk_q[g] <= 2'b00;
      else if (wr_en && (wr_sector == SW'(g)) && !lk_q[g][1])
        lk_q[g] <= wr_bits;
    end

    // R9
    lockdown_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      lk_q[g][1] |=> $stable(lk_q[g]));
  end

  assign rd_lock = {6'b0, lk_q[rd_sector]};
endmodule

// File: rtl/lockreg_spi_top.sv
module lockreg_spi_top
  import lockreg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             spi_cs_n,
  input  logic             spi_sclk,
  input  logic             spi_mosi,
  input  logic             busy_in,
  input  logic [SEC_W-1:0] rd_sector,
  output logic [7:0]       rd_lock,
  output logic             wel_o
);
  logic             byte_stb, frame_end, wr_en;
  logic [7:0]       byte_val;
  logic [2:0]       byte_idx;
  logic [CNT_W-1:0] bit_cnt;
  logic [SEC_W-1:0] wr_sector;
  logic [1:0]       wr_bits;

  spi_bit_rx #(.CW(CNT_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .cs_n(spi_cs_n), .sclk(spi_sclk), .mosi(spi_mosi),
    .byte_stb(byte_stb), .byte_val(byte_val), .byte_idx(byte_idx),
    .frame_end(frame_end), .bit_cnt(bit_cnt)
  );

  lockreg_decode #(.CW(CNT_W), .SW(SEC_W)) u_dec (
    .clk(clk), .rst_n(rst_n), .byte_stb(byte_stb), .byte_val(byte_val),
    .byte_idx(byte_idx), .frame_end(frame_end), .bit_cnt(bit_cnt),
    .busy_in(busy_in), .wr_en(wr_en), .wr_sector(wr_sector),
    .wr_bits(wr_bits), .wel_q(wel_o)
  );

  lockreg_bank #(.NS(NUM_SECTORS), .SW(SEC_W)) u_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sector(wr_sector),
    .wr_bits(wr_bits), .rd_sector(rd_sector), .rd_lock(rd_lock)
  );

  // R5
  no_wr_without_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> wel_o);
  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_lock[7:2] == 6'b0);
  // R7
  busy_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_in |-> !wr_en);
endmodule

// File: tb/sim_lockreg_spi_top.sv
module sim_lockreg_spi_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0, busy = 1'b0;
  logic [4:0] rd_sec = '0;
  logic [7:0] rd_lock;
  logic       wel;
  int         n_chk = 0, n_bad = 0;
  bit         done = 1'b0;

  always #2 clk = ~clk;

  lockreg_spi_top u0 (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_mosi(mosi),
    .busy_in(busy), .rd_sector(rd_sec), .rd_lock(rd_lock), .wel_o(wel)
  );

  // {wren, busy, opcode, addr24, data, nbits, rd_sec, exp_lock, exp_wel}
  typedef struct packed {
    logic        wren;
    logic        busy;
    logic [7:0]  op;
    logic [23:0] addr;
    logic [7:0]  data;
    logic [5:0]  nbits;
    logic [4:0]  sec;
    logic [7:0]  exp_lock;
    logic        exp_wel;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'hE5, 24'h031234, 8'h01, 6'd40, 5'd3,  8'h01, 1'b0}, // R3 R8
    '{1'b1, 1'b0, 8'hE5, 24'h03FFFF, 8'h02, 6'd40, 5'd3,  8'h02, 1'b0}, // R4
    '{1'b0, 1'b0, 8'hE5, 24'h050000, 8'h01, 6'd40, 5'd5,  8'h00, 1'b0}, // R5
    '{1'b1, 1'b0, 8'hE5, 24'h050000, 8'h01, 6'd39, 5'd5,  8'h00, 1'b1}, // R6 short
    '{1'b0, 1'b0, 8'hE5, 24'h050000, 8'h01, 6'd41, 5'd5,  8'h00, 1'b1}, // R6 long
    '{1'b0, 1'b1, 8'hE5, 24'h050000, 8'h03, 6'd40, 5'd5,  8'h00, 1'b1}, // R7
    '{1'b0, 1'b0, 8'hE5, 24'h050000, 8'hFD, 6'd40, 5'd5,  8'h01, 1'b0}, // R3 upper bits
    '{1'b1, 1'b0, 8'hE5, 24'h030000, 8'h00, 6'd40, 5'd3,  8'h02, 1'b0}, // R9
    '{1'b1, 1'b0, 8'h04, 24'h1F0000, 8'h03, 6'd40, 5'd31, 8'h00, 1'b1}, // R11
    '{1'b0, 1'b0, 8'hE5, 24'h1F8000, 8'h03, 6'd40, 5'd31, 8'h03, 1'b0}, // R3 R4 top
    '{1'b0, 1'b0, 8'h06, 24'h000000, 8'h00, 6'd16, 5'd0,  8'h00, 1'b0}  // R2 long
  };

  task automatic check(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic send(input logic [39:0] bits, input int n);
    @(negedge clk) cs_n = 1'b0;
    for (int i = 0; i < n; i++) begin
      mosi = (i < 40) ? bits[39-i] : 1'b0;
      @(negedge clk) sclk = 1'b1;
      @(negedge clk) sclk = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
    @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #400000;
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic all_zero;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    all_zero = 1'b1;
    for (int s = 0; s < 32; s++) begin
      rd_sec = 5'(s); #0.5;
      if (rd_lock !== 8'h00) all_zero = 1'b0;
    end
    check("R1 reset locks", {1'b0, 7'b0, all_zero}, 9'h001);
    check("R1 reset wel", {8'h00, wel}, 9'h000);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].wren) send({8'h06, 32'h0}, 8);
      busy = VECS[v].busy;
      send({VECS[v].op, VECS[v].addr, VECS[v].data}, int'(VECS[v].nbits));
      busy = 1'b0;
      rd_sec = VECS[v].sec;
      @(negedge clk);
      check($sformatf("vec%0d lock", v), {1'b0, rd_lock}, {1'b0, VECS[v].exp_lock});
      check($sformatf("vec%0d wel", v), {8'h00, wel}, {8'h00, VECS[v].exp_wel});
    end

    // R2 short WREN frame leaves latch clear
    send({8'h06, 32'h0}, 7);
    check("R2 short wren", {8'h00, wel}, 9'h000);

    // R10 aborted frame then clean WREN
    send({8'h06, 32'h0}, 5);
    send({8'h06, 32'h0}, 8);
    check("R10 restart after abort", {8'h00, wel}, 9'h001);
    send({8'hE5, 24'h0A0000, 8'h01}, 40);
    rd_sec = 5'd10; @(negedge clk);
    check("R10 write after abort", {1'b0, rd_lock}, 9'h001);

    // R1 reset mid-operation clears locks and latch
    send({8'h06, 32'h0}, 8);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    rd_sec = 5'd3; @(negedge clk);
    check("R1 reset sector3", {1'b0, rd_lock}, 9'h000);
    check("R1 reset wel again", {8'h00, wel}, 9'h000);

    // R9 lock-down cleared by reset: sector 3 writable again
    send({8'h06, 32'h0}, 8);
    send({8'hE5, 24'h030000, 8'h01}, 40);
    check("R9 writable after reset", {1'b0, rd_lock}, 9'h001);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule